// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It takes the memory from power-on to an idle, fully programmed state. Clock enable and on-die termination stay low, and the command bus stays deselected, until the supply and the clock are both reported stable. It then counts a configurable stabilisation interval, raises clock enable with NOPs, and issues a fixed series of commands: two Precharge All, the four mode-register loads, two Auto Refresh, and a closing mode-register load. A single down-counter times every gap. When the DLL lock window has passed, the block raises `init_done`.

All wait intervals given in time units are turned into clock cycles at elaboration, from the clock period parameter, by rounding up. The command-to-command gaps after a mode-register load, a precharge and a refresh are parameters counted in cycles. The mode-register contents come in on configuration inputs. The block forces only the DLL control bits it must own: it enables the DLL in EMR(1) and sets or clears DLL reset in the two MR loads. Once `init_done` is high, the normal memory scheduler takes over the bus.

Top module: `ddr2_init_seq`

## Requirements
- R1: A low `rst_n`, sampled at a rising clock edge, returns the block to its start state. From that edge on, `cke`=0, `odt`=0, `cs_n`=1 and `init_done`=0, and the whole sequence runs again from the beginning.
- R2: `odt` is never high. While `cke` is low, `cs_n` is held at 1 (deselect).
- R3: The stabilisation wait starts only while both `pwr_ok` and `clk_ok` are high. If either one falls during the wait, the wait is abandoned and `cke` stays low until both are high again.
- R4: The wait lasts N = ceil(STABLE_WAIT_NS*1000/CLK_PERIOD_PS) cycles. `cke` rises after exactly N+2 rising edges, counting the first edge that samples both stable inputs high as edge 1.
- R5: After `cke` rises, only NOP ({cs_n,ras_n,cas_n,we_n}=0111) is driven until the first Precharge All. That command appears ceil(CKE_WAIT_NS*1000/CLK_PERIOD_PS)+1 cycles after the `cke` rise.
- R6: Precharge All is encoded as {ras_n,cas_n,we_n}=010 with `addr[10]`=1.
- R7: The commands appear in this order: Precharge All, EMR(2), EMR(3), EMR(1), MR with DLL reset, Precharge All, Auto Refresh, Auto Refresh, MR without DLL reset. No other command appears.
- R8: A mode-register load is encoded as {ras_n,cas_n,we_n}=000. It drives `ba`=00 for MR, 01 for EMR(1), 10 for EMR(2) and 11 for EMR(3), and it places the matching configuration input on `addr`.
- R9: The EMR(1) load forces `addr[0]`=0 (DLL enabled). The first MR load forces `addr[8]`=1 (DLL reset). The last MR load forces `addr[8]`=0.
- R10: Consecutive commands are spaced T+1 cycles apart, with T NOP cycles between them. T is TMRD_CYC after a mode-register load, TRP_CYC after a precharge and TRFC_CYC after an Auto Refresh. Auto Refresh is encoded as {ras_n,cas_n,we_n}=001.
- R11: `init_done` rises exactly DLL_LOCK_CYC cycles after the DLL-reset MR load appears on the bus. After that, `init_done` and `cke` stay high and the bus carries only NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supplies reported stable |
| clk_ok | input | 1 | Memory clock reported stable |
| mr_cfg | input | ADDR_W | Main mode register contents |
| emr1_cfg | input | ADDR_W | EMR(1) contents |
| emr2_cfg | input | ADDR_W | EMR(2) contents |
| emr3_cfg | input | ADDR_W | EMR(3) contents |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination control |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / mode-register select |
| addr | output | ADDR_W | Address / mode-register data |
| init_done | output | 1 | Initialization complete |

## Verification
The hardest cases to reach from the ports are a loss of stability in the middle of the long stabilisation wait, and a reset that arrives partway through the command series. The bench shortens the wait to a few hundred cycles with a value that is not a whole number of clock periods, so the rounding is exercised. It drops `pwr_ok` for one cycle deep inside the wait and then measures the full wait again from the moment stability returns. Later it re-runs the sequence and pulls `rst_n` low after a few mode-register loads have been issued, then checks that the bus and `init_done` fall back to their start values.

// File: rtl/ddr2init_pkg.sv
`timescale 1ns/1ps
// Package: shared step and command encodings for the DDR2 init sequencer.
// Assumes the command op field is packed as {ras_n, cas_n, we_n}.
package ddr2init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_CKE,
        ST_PRE_A,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1,
        ST_MR_RST,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_MR_RUN,
        ST_LOCK,
        ST_DONE
    } step_e;

    typedef enum logic [2:0] {
        OP_MRS = 3'b000,
        OP_REF = 3'b001,
        OP_PRE = 3'b010,
        OP_NOP = 3'b111
    } op_e;

    // Integer division that rounds up; used for ns/us to cycle conversion.
    function automatic int ceil_div(longint num, longint den);
        return int'((num + den - 1) / den);
    endfunction

    // Larger of two integers; used for counter sizing.
    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2init_timer.sv
`timescale 1ns/1ps
// Module: shared down-counter that times every wait of the sequencer.
// A load sets the count; it then decrements to zero and holds there.
// Assumes the loader never asks for a value wider than CNT_W.
module ddr2init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down after a load; reset leaves the counter at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero detect drives the sequencer's advance decision.
    always_comb begin
        expired = (cnt_q == '0);
    end

    // R10
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/ddr2init_seq.sv
`timescale 1ns/1ps
// Module: step sequencer for DDR2 power-up.
// Walks the fixed step list. Each timed step has one issue cycle that
// loads the shared timer with its gap, then waits for the timer to expire.
// Assumes every gap parameter is at least 1 cycle.
module ddr2init_seq
    import ddr2init_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int N_STABLE = 25000,
    parameter int N_CKE    = 50,
    parameter int TMRD     = 2,
    parameter int TRP      = 4,
    parameter int TRFC     = 14,
    parameter int N_LOCK   = 158
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stable,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output step_e            step,
    output logic             issue
);

    step_e step_q, step_d;
    logic  issue_q;

    // Gap in cycles that follows the issue cycle of a timed step.
    function automatic int gap_of(step_e s);
        case (s)
            ST_CKE:                        return N_CKE;
            ST_PRE_A, ST_PRE_B:            return TRP;
            ST_EMR2, ST_EMR3, ST_EMR1,
            ST_MR_RST, ST_MR_RUN:          return TMRD;
            ST_REF_A, ST_REF_B:            return TRFC;
            ST_LOCK:                       return N_LOCK;
            default:                       return 1;
        endcase
    endfunction

    // Fixed successor of each timed step.
    function automatic step_e next_of(step_e s);
        case (s)
            ST_CKE:    return ST_PRE_A;
            ST_PRE_A:  return ST_EMR2;
            ST_EMR2:   return ST_EMR3;
            ST_EMR3:   return ST_EMR1;
            ST_EMR1:   return ST_MR_RST;
            ST_MR_RST: return ST_PRE_B;
            ST_PRE_B:  return ST_REF_A;
            ST_REF_A:  return ST_REF_B;
            ST_REF_B:  return ST_MR_RUN;
            ST_MR_RUN: return ST_LOCK;
            default:   return ST_DONE;
        endcase
    endfunction

    // Next-step and timer-load decision.
    always_comb begin
        step_d   = step_q;
        load     = 1'b0;
        load_val = CNT_W'(gap_of(step_q) - 1);
        case (step_q)
            ST_IDLE: begin
                if (stable) begin
                    step_d   = ST_PWR;
                    load     = 1'b1;
                    load_val = CNT_W'(N_STABLE - 1);
                end
            end
            ST_PWR: begin
                if (!stable)      step_d = ST_IDLE;
                else if (expired) step_d = ST_CKE;
            end
            ST_DONE: begin
                step_d = ST_DONE;
            end
            default: begin
                if (issue_q)      load   = 1'b1;
                else if (expired) step_d = next_of(step_q);
            end
        endcase
    end

    // Step register and first-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_IDLE;
            issue_q <= 1'b0;
        end else begin
            step_q  <= step_d;
            issue_q <= (step_d != step_q);
        end
    end

    // Present step state to the command encoder.
    always_comb begin
        step  = step_q;
        issue = issue_q;
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_IDLE && !stable) |=> step_q == ST_IDLE);

    // R4
    pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_PWR && stable && !expired) |=> step_q == ST_PWR);

    // R10
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(step_q inside {ST_IDLE, ST_PWR, ST_DONE}) && !issue_q && !expired)
        |=> step_q == $past(step_q));

endmodule

// File: rtl/ddr2init_cmd.sv
`timescale 1ns/1ps
// Module: command encoder. Turns the current step into registered
// CKE, command, bank and address outputs. Commands are driven only in
// the issue cycle of a step; every other cycle carries NOP or deselect.
// Assumes ADDR_W >= 11 so that A10 and A8 exist.
module ddr2init_cmd
    import ddr2init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic              issue,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr1_cfg,
    input  logic [ADDR_W-1:0] emr2_cfg,
    input  logic [ADDR_W-1:0] emr3_cfg,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam int A_PALL   = 10;
    localparam int A_DLLRST = 8;
    localparam int A_DLLDIS = 0;

    op_e               op_d, op_q;
    logic              cke_d, cs_n_d, done_d;
    logic [1:0]        ba_d;
    logic [ADDR_W-1:0] addr_d;

    // Decode step into the next bus value.
    always_comb begin
        op_d   = OP_NOP;
        ba_d   = 2'b00;
        addr_d = '0;
        cke_d  = !(step inside {ST_IDLE, ST_PWR});
        cs_n_d = !cke_d;
        done_d = (step == ST_DONE);
        if (issue) begin
            case (step)
                ST_PRE_A, ST_PRE_B: begin
                    op_d           = OP_PRE;
                    addr_d[A_PALL] = 1'b1;
                end
                ST_EMR2: begin
                    op_d   = OP_MRS;
                    ba_d   = 2'b10;
                    addr_d = emr2_cfg;
                end
                ST_EMR3: begin
                    op_d   = OP_MRS;
                    ba_d   = 2'b11;
                    addr_d = emr3_cfg;
                end
                ST_EMR1: begin
                    op_d             = OP_MRS;
                    ba_d             = 2'b01;
                    addr_d           = emr1_cfg;
                    addr_d[A_DLLDIS] = 1'b0;
                end
                ST_MR_RST: begin
                    op_d             = OP_MRS;
                    addr_d           = mr_cfg;
                    addr_d[A_DLLRST] = 1'b1;
                end
                ST_MR_RUN: begin
                    op_d             = OP_MRS;
                    addr_d           = mr_cfg;
                    addr_d[A_DLLRST] = 1'b0;
                end
                ST_REF_A, ST_REF_B: begin
                    op_d = OP_REF;
                end
                default: begin
                    op_d = OP_NOP;
                end
            endcase
        end
    end

    // Output registers; reset puts the bus in deselect with CKE low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_NOP;
            cke  <= 1'b0;
            cs_n <= 1'b1;
            ba   <= 2'b00;
            addr <= '0;
            done <= 1'b0;
            odt  <= 1'b0;
        end else begin
            op_q <= op_d;
            cke  <= cke_d;
            cs_n <= cs_n_d;
            ba   <= ba_d;
            addr <= addr_d;
            done <= done_d;
            odt  <= 1'b0;
        end
    end

    // Split the op field onto the strobe pins.
    always_comb begin
        {ras_n, cas_n, we_n} = op_q;
    end

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
// Module: top of the DDR2 power-up initialization sequencer.
// Converts time parameters to cycles (rounding up), sizes the shared
// timer and places the lock remainder so init_done lands DLL_LOCK_CYC
// cycles after the DLL-reset load. Assumes ADDR_W >= 11.
module ddr2_init_seq
    import ddr2init_pkg::*;
#(
    parameter int CLK_PERIOD_PS  = 8000,
    parameter int STABLE_WAIT_NS = 200000,
    parameter int CKE_WAIT_NS    = 400,
    parameter int TMRD_CYC       = 2,
    parameter int TRP_CYC        = 4,
    parameter int TRFC_CYC       = 14,
    parameter int DLL_LOCK_CYC   = 200,
    parameter int ADDR_W         = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              clk_ok,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr1_cfg,
    input  logic [ADDR_W-1:0] emr2_cfg,
    input  logic [ADDR_W-1:0] emr3_cfg,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int N_STABLE = imax(ceil_div(longint'(STABLE_WAIT_NS) * 1000, CLK_PERIOD_PS), 1);
    localparam int N_CKE    = imax(ceil_div(longint'(CKE_WAIT_NS) * 1000, CLK_PERIOD_PS), 1);
    // Cycles from the DLL-reset load to the lock step's issue cycle.
    localparam int TAIL     = 2 * TMRD_CYC + TRP_CYC + 2 * TRFC_CYC + 5;
    localparam int N_LOCK   = (DLL_LOCK_CYC - 1 > TAIL) ? (DLL_LOCK_CYC - 1 - TAIL) : 1;
    localparam int MAX_GAP  = imax(imax(N_STABLE, N_CKE), imax(imax(TRFC_CYC, N_LOCK), imax(TRP_CYC, TMRD_CYC)));
    localparam int CNT_W    = $clog2(MAX_GAP + 1);

    logic             stable;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    step_e            step;
    logic             issue;

    // Both stability indications must be present to start or hold the wait.
    always_comb begin
        stable = pwr_ok && clk_ok;
    end

    ddr2init_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ddr2init_seq #(
        .CNT_W    (CNT_W),
        .N_STABLE (N_STABLE),
        .N_CKE    (N_CKE),
        .TMRD     (TMRD_CYC),
        .TRP      (TRP_CYC),
        .TRFC     (TRFC_CYC),
        .N_LOCK   (N_LOCK)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stable   (stable),
        .expired  (tmr_expired),
        .load     (tmr_load),
        .load_val (tmr_val),
        .step     (step),
        .issue    (issue)
    );

    ddr2init_cmd #(.ADDR_W(ADDR_W)) i_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .issue    (issue),
        .mr_cfg   (mr_cfg),
        .emr1_cfg (emr1_cfg),
        .emr2_cfg (emr2_cfg),
        .emr3_cfg (emr3_cfg),
        .cke      (cke),
        .odt      (odt),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .done     (init_done)
    );

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R11
    done_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && !cs_n && ras_n && cas_n && we_n));

    // R6
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);

    // R9
    emr1_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n && ba == 2'b01) |-> !addr[0]);

endmodule

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

    localparam int AW       = 13;
    localparam int N_STAB   = 251;  // ceil(2004*1000/8000)
    localparam int N_CKEW   = 50;   // 400*1000/8000
    localparam int TMRD     = 2;
    localparam int TRP      = 4;
    localparam int TRFC     = 14;
    localparam int DLL_LOCK = 200;

    typedef struct {
        logic [2:0]    op;
        logic          ba_chk;
        logic [1:0]    ba;
        logic [AW-1:0] addr;
        logic [AW-1:0] mask;
        int            gap;
        bit            from_cke;
        bit            dll_rst;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          clk_ok = 1'b0;
    logic [AW-1:0] mr_cfg   = 13'h0533;
    logic [AW-1:0] emr1_cfg = 13'h0045;
    logic [AW-1:0] emr2_cfg = 13'h0080;
    logic [AW-1:0] emr3_cfg = 13'h0001;
    logic          cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]    ba;
    logic [AW-1:0] addr;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    int   cke_edge = 0;
    int   last_cmd = 0;
    int   rst_edge = 0;
    int   odt_bad  = 0;
    int   sel_bad  = 0;
    bit   mon_en   = 1'b1;
    bit   cke_prev = 1'b0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    ddr2_init_seq #(
        .CLK_PERIOD_PS  (8000),
        .STABLE_WAIT_NS (2004),
        .CKE_WAIT_NS    (400),
        .TMRD_CYC       (TMRD),
        .TRP_CYC        (TRP),
        .TRFC_CYC       (TRFC),
        .DLL_LOCK_CYC   (DLL_LOCK),
        .ADDR_W         (AW)
    ) i_ddr2_init_seq (
        .clk (clk), .rst_n (rst_n), .pwr_ok (pwr_ok), .clk_ok (clk_ok),
        .mr_cfg (mr_cfg), .emr1_cfg (emr1_cfg), .emr2_cfg (emr2_cfg), .emr3_cfg (emr3_cfg),
        .cke (cke), .odt (odt), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic bc, input logic [1:0] b,
                        input logic [AW-1:0] a, input logic [AW-1:0] m, input int g,
                        input bit fc, input bit dr, input string r);
        exp_t e;
        e.op = op; e.ba_chk = bc; e.ba = b; e.addr = a; e.mask = m;
        e.gap = g; e.from_cke = fc; e.dll_rst = dr; e.req = r;
        exp_q.push_back(e);
    endtask

    // Driver: expected command series per R5..R10.
    task automatic push_sequence();
        push(3'b010, 1'b0, 2'b00, 13'h0400, 13'h0400, N_CKEW + 1, 1'b1, 1'b0, "R5/R6");
        push(3'b000, 1'b1, 2'b10, emr2_cfg, '1, TRP + 1, 1'b0, 1'b0, "R7/R8");
        push(3'b000, 1'b1, 2'b11, emr3_cfg, '1, TMRD + 1, 1'b0, 1'b0, "R7/R8");
        push(3'b000, 1'b1, 2'b01, emr1_cfg & ~13'h0001, '1, TMRD + 1, 1'b0, 1'b0, "R8/R9");
        push(3'b000, 1'b1, 2'b00, mr_cfg | 13'h0100, '1, TMRD + 1, 1'b0, 1'b1, "R8/R9");
        push(3'b010, 1'b0, 2'b00, 13'h0400, 13'h0400, TMRD + 1, 1'b0, 1'b0, "R6/R7");
        push(3'b001, 1'b0, 2'b00, '0, '0, TRP + 1, 1'b0, 1'b0, "R7/R10");
        push(3'b001, 1'b0, 2'b00, '0, '0, TRFC + 1, 1'b0, 1'b0, "R7/R10");
        push(3'b000, 1'b1, 2'b00, mr_cfg & ~13'h0100, '1, TRFC + 1, 1'b0, 1'b0, "R9/R10");
    endtask

    // Monitor: pops expected items as commands appear on the bus.
    always @(negedge clk) begin
        if (rst_n && cke && !cke_prev) cke_edge = cyc;
        cke_prev = cke;
        if (odt) odt_bad++;
        if (!cke && !cs_n) sel_bad++;
        if (mon_en && rst_n && !cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected command op", {ras_n, cas_n, we_n}, 7);
            end else begin
                exp_t e;
                int   g;
                e = exp_q.pop_front();
                check({ras_n, cas_n, we_n} == e.op, e.req, "command op", {ras_n, cas_n, we_n}, e.op);
                if (e.ba_chk) check(ba == e.ba, e.req, "bank select", ba, e.ba);
                check((addr & e.mask) == (e.addr & e.mask), e.req, "address", addr & e.mask, e.addr & e.mask);
                g = e.from_cke ? (cyc - cke_edge) : (cyc - last_cmd);
                check(g == e.gap, e.from_cke ? "R5" : "R10", "cycles since previous event", g, e.gap);
                if (e.dll_rst) rst_edge = cyc;
            end
            last_cmd = cyc;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Count rising edges until cke goes high (or limit).
    task automatic edges_to_cke(output int n);
        n = 0;
        while (!cke && n < 5000) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cke == 1'b0, "R1", "cke in reset", cke, 0);
        check(odt == 1'b0, "R1", "odt in reset", odt, 0);
        check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        check(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
        rst_n = 1'b1;

        // R3: power good alone does not start anything
        pwr_ok = 1'b1;
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cke) bad++;
        end
        check(bad == 0, "R3", "cke high cycles without clk_ok", bad, 0);

        // R3: stability lost inside the wait restarts it
        clk_ok = 1'b1;
        repeat (100) @(negedge clk);
        pwr_ok = 1'b0;
        @(negedge clk);
        check(cke == 1'b0, "R3", "cke after stability loss", cke, 0);
        push_sequence();
        pwr_ok = 1'b1;
        edges_to_cke(n);
        // R4
        check(n == N_STAB + 2, "R4", "edges from stable to cke rise", n, N_STAB + 2);
        check(sel_bad == 0, "R2", "cycles with command while cke low", sel_bad, 0);

        n = 0;
        while (!init_done && n < 3000) begin
            @(negedge clk); n++;
        end
        // R11
        check(init_done == 1'b1, "R11", "init_done reached", init_done, 1);
        check(cyc - rst_edge == DLL_LOCK, "R11", "cycles DLL-reset load to init_done", cyc - rst_edge, DLL_LOCK);
        check(exp_q.size() == 0, "R7", "commands still expected", exp_q.size(), 0);

        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!init_done || !cke || cs_n || {ras_n, cas_n, we_n} != 3'b111) bad++;
        end
        check(bad == 0, "R11", "non-idle cycles after init_done", bad, 0);

        // R1: reset after completion restarts the sequence
        rst_n = 1'b0;
        @(negedge clk);
        check(init_done == 1'b0, "R1", "init_done after reset", init_done, 0);
        check(cke == 1'b0, "R1", "cke after reset", cke, 0);
        push_sequence();
        rst_n = 1'b1;
        edges_to_cke(n);
        check(n == N_STAB + 2, "R1", "edges from reset release to cke rise", n, N_STAB + 2);

        // R1: reset in the middle of the command series
        n = 0;
        while (exp_q.size() > 5 && n < 500) begin
            @(negedge clk); n++;
        end
        mon_en = 1'b0;
        exp_q.delete();
        rst_n = 1'b0;
        @(negedge clk);
        check(cke == 1'b0 && cs_n == 1'b1, "R1", "cke/cs_n after mid-sequence reset", {cke, cs_n}, 1);
        check(init_done == 1'b0, "R1", "init_done after mid-sequence reset", init_done, 0);
        // R2
        check(odt_bad == 0, "R2", "cycles with odt high", odt_bad, 0);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", cyc, 150000);
        report();
    end

endmodule